// File: doc/BRIEF.md
# Addressed Sensor Command Decoder

This block is the transaction layer of a sensor's single-wire slave port. It sits behind a byte receiver that has already recovered the bits. The receiver gives the block a marker at the start of every transaction and then one strobe per received byte. The first byte after the marker must be the calibration byte 55h. The next byte is a command, which either names a fixed broadcast operation or selects one of four 16-bit registers for a read or a write. A write is followed by two data bytes from the host. A read makes the block hand two reply bytes to the transmitter, one at a time, through a request/acknowledge pair.

A command is global when every device on the wire obeys it. It is individual when only the device whose local 4-bit identifier matches the identifier field obeys it. The four fixed broadcast opcodes produce one-cycle strobes for software reset, initialisation, address assignment and interrupt clear. The software reset also returns the registers to their reset values. The temperature register is read-only from the wire. It is loaded from the conversion side through a separate update port.

Top module: `sensor_cmd_decoder`

## Requirements
- R1: While `rst` is high and on the first cycle after it, the register outputs read temperature 0000h, configuration 0200h, low limit F600h and high limit 3C00h. `tx_req` and all four strobes are low.
- R2: A command byte is decoded as follows. Bit 7 is the global flag, bits 6:3 are the device identifier, bits 2:1 are the register pointer and bit 0 is 1 for a read. The pointer maps 00 to temperature, 01 to configuration, 10 to low limit and 11 to high limit. A command with bit 7 clear is obeyed only when bits 6:3 equal `dev_id`.
- R3: The commands F0h|(ptr<<1) (global write) and F1h|(ptr<<1) (global read) are obeyed whatever `dev_id` holds.
- R4: A write to pointer 00 consumes its data bytes but leaves `temp_q` unchanged. `temp_q` takes `temp_val` on the cycle after `temp_upd` is high.
- R5: Write data arrives low byte first. The selected register changes on the clock edge that accepts the high byte, and not after the low byte alone.
- R6: After a read command is accepted, `tx_req` rises on the next cycle with the register's low byte on `tx_byte`. On the first `tx_ack`, the high byte follows on the next cycle. On the second `tx_ack`, `tx_req` falls. The reply uses the register value at the time of the command.
- R7: Opcode B4h pulses `sw_reset_pulse` and `clr_int_pulse` together for one cycle. On the same edge it returns all four registers to their R1 values.
- R8: Opcode 8Ch pulses only `init_pulse`, opcode 90h pulses only `addr_assign_pulse` and opcode A9h pulses only `clr_int_pulse`. Each pulse lasts one cycle and leaves the registers unchanged.
- R9: A command byte that fits no encoding, or an individual command naming another identifier, is ignored. Every byte after it is also ignored until the next `rx_sot`.
- R10: A command is only taken after `rx_sot` followed by the calibration byte 55h. A different first byte, or bytes received with no preceding `rx_sot`, change nothing.
- R11: `rx_sot` restarts the transaction from any state. It discards a partial write and withdraws a pending reply (`tx_req` low on the next cycle).
- R12: While `tx_req` is high and `tx_ack` is low, `tx_req` and `tx_byte` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_sot | input | 1 | Start-of-transaction marker from the receiver |
| rx_valid | input | 1 | One-cycle strobe for a received byte |
| rx_byte | input | 8 | Received byte |
| dev_id | input | ID_W | Local device identifier |
| temp_upd | input | 1 | Load strobe from the conversion side |
| temp_val | input | DATA_W | New temperature result |
| tx_ack | input | 1 | Transmitter has taken `tx_byte` |
| tx_req | output | 1 | Reply byte is waiting |
| tx_byte | output | 8 | Reply byte |
| temp_q | output | DATA_W | Temperature result register |
| cfg_q | output | DATA_W | Configuration register |
| lo_lim_q | output | DATA_W | Low limit register |
| hi_lim_q | output | DATA_W | High limit register |
| sw_reset_pulse | output | 1 | Software reset strobe |
| init_pulse | output | 1 | Initialisation strobe |
| addr_assign_pulse | output | 1 | Address assignment strobe |
| clr_int_pulse | output | 1 | Interrupt clear strobe |

## Verification
The assertions take for granted that the receiver never raises `rx_valid` more often than one byte per cycle. They also assume that two opcode bytes are always separated by a marker and a calibration byte, so a strobe can never be high on two cycles in a row. They further assume that `tx_ack` only comes while `tx_req` is high, and that `dev_id` is steady within a transaction. The stimulus keeps to these conditions: it sends every byte as a single-cycle strobe followed by an idle cycle, changes `dev_id` only between transactions, and acknowledges reply bytes only after it has seen `tx_req`, sometimes after several wait cycles.

// File: rtl/sdec_pkg.sv
package sdec_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CAL,
    ST_CMD,
    ST_WDATA,
    ST_REPLY
  } dec_state_e;

  typedef enum logic [2:0] {
    K_NONE,
    K_SWRST,
    K_INIT,
    K_ADDR,
    K_CLRINT,
    K_WRITE,
    K_READ
  } cmd_kind_e;

  localparam logic [7:0] OP_SWRST  = 8'hB4;
  localparam logic [7:0] OP_INIT   = 8'h8C;
  localparam logic [7:0] OP_ADDR   = 8'h90;
  localparam logic [7:0] OP_CLRINT = 8'hA9;

  function automatic logic [15:0] reg_reset_value(input int idx);
    case (idx)
      0:       return 16'h0000;
      1:       return 16'h0200;
      2:       return 16'hF600;
      default: return 16'h3C00;
    endcase
  endfunction

endpackage

// File: rtl/sdec_cmd_decode.sv
module sdec_cmd_decode
  import sdec_pkg::*;
#(
  parameter int ID_W  = 4,
  parameter int PTR_W = 2
) (
  input  logic [ID_W+PTR_W+1:0] cmd,
  input  logic [ID_W-1:0]       my_id,
  output cmd_kind_e             kind,
  output logic [PTR_W-1:0]      ptr
);
  localparam int RW_BIT   = 0;
  localparam int PTR_LSB  = 1;
  localparam int ID_LSB   = PTR_LSB + PTR_W;
  localparam int FLAG_BIT = ID_LSB + ID_W;
  localparam int CMD_W    = FLAG_BIT + 1;
  localparam logic [ID_W-1:0] GLB_ID = ~ID_W'(1);

  logic [ID_W-1:0] id_field;
  logic            addressed;

  assign id_field  = cmd[ID_LSB +: ID_W];
  assign ptr       = cmd[PTR_LSB +: PTR_W];
  assign addressed = cmd[FLAG_BIT] ? (id_field == GLB_ID) : (id_field == my_id);

  always_comb begin
    kind = K_NONE;
    if (cmd == CMD_W'(OP_SWRST))       kind = K_SWRST;
    else if (cmd == CMD_W'(OP_INIT))   kind = K_INIT;
    else if (cmd == CMD_W'(OP_ADDR))   kind = K_ADDR;
    else if (cmd == CMD_W'(OP_CLRINT)) kind = K_CLRINT;
    else if (addressed)                kind = cmd[RW_BIT] ? K_READ : K_WRITE;
  end

endmodule

// File: rtl/sdec_regfile.sv
module sdec_regfile
  import sdec_pkg::*;
#(
  parameter int W  = 16,
  parameter int IW = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      sw_clr,
  input  logic                      wr_en,
  input  logic [IW-1:0]             wr_idx,
  input  logic [W-1:0]              wr_data,
  input  logic                      temp_upd,
  input  logic [W-1:0]              temp_val,
  output logic [(1<<IW)-1:0][W-1:0] regs_q
);
  localparam int NREG = 1 << IW;

  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [W-1:0] RV = W'(reg_reset_value(i));
    logic [W-1:0] r;
    assign regs_q[i] = r;

    if (i == 0) begin : g_ro
      always_ff @(posedge clk) begin
        if (rst || sw_clr)  r <= RV;
        else if (temp_upd)  r <= temp_val;
      end

      assert_temp_bus_ro_R4: assert property (@(posedge clk) disable iff (rst || !past_ok)
        (r != $past(r)) |-> ($past(temp_upd) || $past(sw_clr)))
        else $error("temperature register changed without an update or reset");
    end else begin : g_rw
      always_ff @(posedge clk) begin
        if (rst || sw_clr)                      r <= RV;
        else if (wr_en && wr_idx == IW'(i))     r <= wr_data;
      end
    end
  end

endmodule

// File: rtl/sdec_reply.sv
module sdec_reply #(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              abort,
  input  logic              start,
  input  logic [DATA_W-1:0] load_val,
  input  logic              tx_ack,
  output logic              tx_req,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              done
);
  localparam int NB = DATA_W / BYTE_W;
  localparam int CW = (NB > 1) ? $clog2(NB) : 1;

  logic [DATA_W-1:0] sh;
  logic [CW-1:0]     sent;
  logic              last;
  logic              past_ok;

  assign tx_byte = sh[BYTE_W-1:0];
  assign last    = (sent == CW'(NB - 1));
  assign done    = tx_req && tx_ack && last;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_req  <= 1'b0;
      sh      <= '0;
      sent    <= '0;
      past_ok <= 1'b0;
    end else begin
      past_ok <= 1'b1;
      if (abort) begin
        tx_req <= 1'b0;
      end else if (start) begin
        tx_req <= 1'b1;
        sh     <= load_val;
        sent   <= '0;
      end else if (tx_req && tx_ack) begin
        if (last) begin
          tx_req <= 1'b0;
        end else begin
          sh   <= sh >> BYTE_W;
          sent <= sent + CW'(1);
        end
      end
    end
  end

  assert_tx_hold_R12: assert property (@(posedge clk) disable iff (rst || !past_ok)
    (tx_req && !tx_ack && !abort) |=> (tx_req && $stable(tx_byte)))
    else $error("reply byte changed while waiting for acknowledge");

endmodule

// File: rtl/sensor_cmd_decoder.sv
module sensor_cmd_decoder
  import sdec_pkg::*;
#(
  parameter int          DATA_W   = 16,
  parameter int          ID_W     = 4,
  parameter logic [7:0]  CAL_BYTE = 8'h55
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_sot,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  input  logic [ID_W-1:0]   dev_id,
  input  logic              temp_upd,
  input  logic [DATA_W-1:0] temp_val,
  input  logic              tx_ack,
  output logic              tx_req,
  output logic [7:0]        tx_byte,
  output logic [DATA_W-1:0] temp_q,
  output logic [DATA_W-1:0] cfg_q,
  output logic [DATA_W-1:0] lo_lim_q,
  output logic [DATA_W-1:0] hi_lim_q,
  output logic              sw_reset_pulse,
  output logic              init_pulse,
  output logic              addr_assign_pulse,
  output logic              clr_int_pulse
);
  localparam int BYTE_W = 8;
  localparam int PTR_W  = 2;
  localparam int NREG   = 1 << PTR_W;
  localparam int NBYTES = DATA_W / BYTE_W;
  localparam int BCW    = (NBYTES > 1) ? $clog2(NBYTES) : 1;
  localparam int AW     = DATA_W - BYTE_W;

  dec_state_e                   st;
  cmd_kind_e                    dec_kind;
  logic [PTR_W-1:0]             dec_ptr;
  logic [PTR_W-1:0]             ptr_q;
  logic [BCW-1:0]               bcnt;
  logic [AW-1:0]                asm_q;
  logic [DATA_W-1:0]            wr_data;
  logic [NREG-1:0][DATA_W-1:0]  regs_q;
  logic                         acc, cmd_take, reg_wr, sw_clr, reply_start, reply_done;
  logic                         past_ok;

  sdec_cmd_decode #(.ID_W(ID_W), .PTR_W(PTR_W)) u_decode (
    .cmd   (rx_byte),
    .my_id (dev_id),
    .kind  (dec_kind),
    .ptr   (dec_ptr)
  );

  assign acc         = rx_valid && !rx_sot;
  assign cmd_take    = (st == ST_CMD) && acc;
  assign sw_clr      = cmd_take && (dec_kind == K_SWRST);
  assign reply_start = cmd_take && (dec_kind == K_READ);
  assign reg_wr      = (st == ST_WDATA) && acc && (bcnt == BCW'(NBYTES - 1));
  assign wr_data     = {rx_byte, asm_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_IDLE;
      ptr_q <= '0;
      bcnt  <= '0;
      asm_q <= '0;
    end else if (rx_sot) begin
      st <= ST_CAL;
    end else begin
      case (st)
        ST_CAL:   if (rx_valid) st <= (rx_byte == CAL_BYTE) ? ST_CMD : ST_IDLE;
        ST_CMD:   if (rx_valid) begin
                    ptr_q <= dec_ptr;
                    bcnt  <= '0;
                    case (dec_kind)
                      K_WRITE: st <= ST_WDATA;
                      K_READ:  st <= ST_REPLY;
                      default: st <= ST_IDLE;
                    endcase
                  end
        ST_WDATA: if (rx_valid) begin
                    asm_q <= wr_data[DATA_W-1:BYTE_W];
                    bcnt  <= bcnt + BCW'(1);
                    if (reg_wr) st <= ST_IDLE;
                  end
        ST_REPLY: if (reply_done) st <= ST_IDLE;
        default:  st <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sw_reset_pulse    <= 1'b0;
      init_pulse        <= 1'b0;
      addr_assign_pulse <= 1'b0;
      clr_int_pulse     <= 1'b0;
      past_ok           <= 1'b0;
    end else begin
      past_ok           <= 1'b1;
      sw_reset_pulse    <= sw_clr;
      init_pulse        <= cmd_take && (dec_kind == K_INIT);
      addr_assign_pulse <= cmd_take && (dec_kind == K_ADDR);
      clr_int_pulse     <= cmd_take && (dec_kind == K_CLRINT || dec_kind == K_SWRST);
    end
  end

  sdec_regfile #(.W(DATA_W), .IW(PTR_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .sw_clr   (sw_clr),
    .wr_en    (reg_wr),
    .wr_idx   (ptr_q),
    .wr_data  (wr_data),
    .temp_upd (temp_upd),
    .temp_val (temp_val),
    .regs_q   (regs_q)
  );

  sdec_reply #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_reply (
    .clk      (clk),
    .rst      (rst),
    .abort    (rx_sot),
    .start    (reply_start),
    .load_val (regs_q[dec_ptr]),
    .tx_ack   (tx_ack),
    .tx_req   (tx_req),
    .tx_byte  (tx_byte),
    .done     (reply_done)
  );

  assign temp_q   = regs_q[0];
  assign cfg_q    = regs_q[1];
  assign lo_lim_q = regs_q[2];
  assign hi_lim_q = regs_q[3];

  assert_cfg_after_last_byte_R5: assert property (@(posedge clk) disable iff (rst || !past_ok)
    (cfg_q != $past(cfg_q)) |-> ($past(reg_wr) || $past(sw_clr)))
    else $error("configuration changed before the high data byte");

  assert_reply_from_cmd_R6: assert property (@(posedge clk) disable iff (rst || !past_ok)
    $rose(tx_req) |-> $past(st == ST_CMD))
    else $error("reply started outside command decoding");

  assert_swrst_with_clr_R7: assert property (@(posedge clk) disable iff (rst || !past_ok)
    sw_reset_pulse |-> (clr_int_pulse && !init_pulse && !addr_assign_pulse))
    else $error("software reset strobe without interrupt clear");

  assert_swrst_single_R7: assert property (@(posedge clk) disable iff (rst || !past_ok)
    sw_reset_pulse |=> !sw_reset_pulse)
    else $error("software reset strobe longer than one cycle");

  assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (rst || !past_ok)
    $onehot0({sw_reset_pulse, init_pulse, addr_assign_pulse}))
    else $error("more than one broadcast strobe at once");

  assert_sot_restart_R11: assert property (@(posedge clk) disable iff (rst || !past_ok)
    rx_sot |=> (st == ST_CAL && !tx_req))
    else $error("start marker did not restart the transaction");

endmodule

// File: tb/sensor_cmd_decoder_tb.sv
module sensor_cmd_decoder_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst, rx_sot, rx_valid, temp_upd, tx_ack;
  logic [7:0]  rx_byte;
  logic [3:0]  dev_id;
  logic [15:0] temp_val;
  logic        tx_req;
  logic [7:0]  tx_byte;
  logic [15:0] temp_q, cfg_q, lo_lim_q, hi_lim_q;
  logic        sw_reset_pulse, init_pulse, addr_assign_pulse, clr_int_pulse;

  sensor_cmd_decoder u_dut (
    .clk(clk), .rst(rst), .rx_sot(rx_sot), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .dev_id(dev_id), .temp_upd(temp_upd), .temp_val(temp_val), .tx_ack(tx_ack),
    .tx_req(tx_req), .tx_byte(tx_byte), .temp_q(temp_q), .cfg_q(cfg_q),
    .lo_lim_q(lo_lim_q), .hi_lim_q(hi_lim_q), .sw_reset_pulse(sw_reset_pulse),
    .init_pulse(init_pulse), .addr_assign_pulse(addr_assign_pulse),
    .clr_int_pulse(clr_int_pulse)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [15:0] m_reg [4];
  logic [15:0] m_snap [4];
  int          m_phase;   // 0 idle, 1 want cal, 2 want cmd, 3 low byte, 4 high byte, 5 replying
  int          m_ptr;
  logic [7:0]  m_lo;
  logic [15:0] m_hold;
  logic [7:0]  m_txbyte;
  bit          m_txreq, m_half, m_sw, m_init, m_addr, m_clr, m_live;

  task automatic model_reset_regs();
    m_reg[0] = 16'h0000; m_reg[1] = 16'h0200; m_reg[2] = 16'hF600; m_reg[3] = 16'h3C00;
  endtask

  always @(posedge clk) begin
    m_snap = m_reg;
    m_sw = 0; m_init = 0; m_addr = 0; m_clr = 0;
    if (rst) begin
      model_reset_regs();
      m_phase = 0; m_txreq = 0; m_txbyte = 8'h00; m_half = 0; m_live = 1;
    end else begin
      if (temp_upd) m_reg[0] = temp_val;
      if (rx_sot) begin
        m_phase = 1; m_txreq = 0;
      end else if (m_phase == 5) begin
        if (tx_ack) begin
          if (!m_half) begin m_half = 1; m_txbyte = m_hold[15:8]; end
          else begin m_txreq = 0; m_phase = 0; end
        end
      end else if (rx_valid) begin
        case (m_phase)
          1: m_phase = (rx_byte == 8'h55) ? 2 : 0;
          2: begin
            m_phase = 0;
            if (rx_byte == 8'hB4) begin model_reset_regs(); m_sw = 1; m_clr = 1; end
            else if (rx_byte == 8'h8C) m_init = 1;
            else if (rx_byte == 8'h90) m_addr = 1;
            else if (rx_byte == 8'hA9) m_clr = 1;
            else if (rx_byte[7:3] == 5'b11110 || (!rx_byte[7] && rx_byte[6:3] == dev_id)) begin
              m_ptr = int'(rx_byte[2:1]);
              if (rx_byte[0]) begin
                m_phase = 5; m_half = 0; m_txreq = 1;
                m_hold = m_snap[m_ptr]; m_txbyte = m_hold[7:0];
              end else m_phase = 3;
            end
          end
          3: begin m_lo = rx_byte; m_phase = 4; end
          4: begin if (m_ptr != 0) m_reg[m_ptr] = {rx_byte, m_lo}; m_phase = 0; end
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (m_live && !finished) begin
      check(temp_q == m_reg[0], "R4", "model temp_q", temp_q, m_reg[0]);
      check(cfg_q == m_reg[1], "R5", "model cfg_q", cfg_q, m_reg[1]);
      check(lo_lim_q == m_reg[2], "R5", "model lo_lim_q", lo_lim_q, m_reg[2]);
      check(hi_lim_q == m_reg[3], "R5", "model hi_lim_q", hi_lim_q, m_reg[3]);
      check(tx_req == m_txreq, "R6", "model tx_req", tx_req, m_txreq);
      check(tx_byte == m_txbyte, "R12", "model tx_byte", tx_byte, m_txbyte);
      check({sw_reset_pulse, init_pulse, addr_assign_pulse, clr_int_pulse} ==
            {m_sw, m_init, m_addr, m_clr}, "R8", "model strobes",
            {sw_reset_pulse, init_pulse, addr_assign_pulse, clr_int_pulse},
            {m_sw, m_init, m_addr, m_clr});
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic put_sot();
    rx_sot = 1; tick(); rx_sot = 0;
  endtask

  task automatic put_byte(input logic [7:0] b);
    rx_valid = 1; rx_byte = b; tick(); rx_valid = 0; tick();
  endtask

  function automatic logic [7:0] ind_cmd(input logic [3:0] id, input logic [1:0] p, input bit rd);
    return {1'b0, id, p, rd};
  endfunction

  function automatic logic [7:0] glb_cmd(input logic [1:0] p, input bit rd);
    return {5'b11110, p, rd};
  endfunction

  task automatic do_write(input logic [7:0] cmd, input logic [15:0] v);
    put_sot(); put_byte(8'h55); put_byte(cmd); put_byte(v[7:0]); put_byte(v[15:8]);
  endtask

  task automatic take_reply(input int gap, output logic [15:0] v);
    v = 16'h0;
    for (int k = 0; k < 2; k++) begin
      for (int n = 0; n < 20 && !tx_req; n++) tick();
      check(tx_req == 1'b1, "R6", "reply request present", tx_req, 1);
      repeat (gap) tick();
      v[k*8 +: 8] = tx_byte;
      tx_ack = 1; tick(); tx_ack = 0;
    end
    tick();
    check(tx_req == 1'b0, "R6", "request dropped after two bytes", tx_req, 0);
  endtask

  task automatic do_read(input logic [7:0] cmd, input int gap, output logic [15:0] v);
    put_sot(); put_byte(8'h55); put_byte(cmd); take_reply(gap, v);
  endtask

  task automatic opcode(input logic [7:0] op, input logic [3:0] exp, input string tag);
    put_sot(); put_byte(8'h55);
    rx_valid = 1; rx_byte = op; tick(); rx_valid = 0;
    check({sw_reset_pulse, init_pulse, addr_assign_pulse, clr_int_pulse} == exp, tag,
          "strobes after opcode", {sw_reset_pulse, init_pulse, addr_assign_pulse, clr_int_pulse}, exp);
    tick();
    check({sw_reset_pulse, init_pulse, addr_assign_pulse, clr_int_pulse} == 4'b0, tag,
          "strobes one cycle only", {sw_reset_pulse, init_pulse, addr_assign_pulse, clr_int_pulse}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    m_live = 0;
    rst = 1; rx_sot = 0; rx_valid = 0; rx_byte = 8'h00; dev_id = 4'h5;
    temp_upd = 0; temp_val = 16'h0; tx_ack = 0;
    repeat (3) tick();
    rst = 0;

    // R1 reset state
    check(temp_q == 16'h0000 && cfg_q == 16'h0200, "R1", "temp/cfg reset", {temp_q, cfg_q}, 32'h00000200);
    check(lo_lim_q == 16'hF600 && hi_lim_q == 16'h3C00, "R1", "limit reset", {lo_lim_q, hi_lim_q}, 32'hF6003C00);
    check(tx_req == 0 && !clr_int_pulse && !sw_reset_pulse, "R1", "idle outputs", tx_req, 0);

    // R2/R5 individual write, check after low byte only
    put_sot(); put_byte(8'h55); put_byte(ind_cmd(4'h5, 2'b01, 0)); put_byte(8'hB2);
    check(cfg_q == 16'h0200, "R5", "cfg unchanged after low byte", cfg_q, 16'h0200);
    put_byte(8'hA1);
    check(cfg_q == 16'hA1B2, "R2", "individual write to cfg", cfg_q, 16'hA1B2);

    // R6/R12 individual read with wait cycles
    do_read(ind_cmd(4'h5, 2'b01, 1), 3, v);
    check(v == 16'hA1B2, "R6", "read reply low then high", v, 16'hA1B2);

    // R3 global write and read with differing ids
    do_write(glb_cmd(2'b11, 0), 16'h1234);
    check(hi_lim_q == 16'h1234, "R3", "global write hi limit", hi_lim_q, 16'h1234);
    dev_id = 4'h9;
    do_read(glb_cmd(2'b11, 1), 0, v);
    check(v == 16'h1234, "R3", "global read hi limit", v, 16'h1234);

    // R9 other id and undefined command
    do_write(ind_cmd(4'h5, 2'b10, 0), 16'h5555);
    check(lo_lim_q == 16'hF600, "R9", "write to other id ignored", lo_lim_q, 16'hF600);
    put_sot(); put_byte(8'h55); put_byte(8'hC0); put_byte(8'hF4); put_byte(8'h11); put_byte(8'h22);
    check(lo_lim_q == 16'hF600 && hi_lim_q == 16'h1234, "R9", "undefined command ignored",
          {lo_lim_q, hi_lim_q}, 32'hF6001234);

    // R4 temperature read-only and update port
    do_write(glb_cmd(2'b00, 0), 16'hBEEF);
    check(temp_q == 16'h0000, "R4", "write to temperature ignored", temp_q, 0);
    temp_upd = 1; temp_val = 16'h0190; tick(); temp_upd = 0;
    check(temp_q == 16'h0190, "R4", "temperature loaded", temp_q, 16'h0190);
    do_read(ind_cmd(4'h9, 2'b00, 1), 1, v);
    check(v == 16'h0190, "R2", "pointer 00 reads temperature", v, 16'h0190);

    // R10 calibration and marker required
    put_sot(); put_byte(8'h54); put_byte(glb_cmd(2'b10, 0)); put_byte(8'h01); put_byte(8'h02);
    check(lo_lim_q == 16'hF600, "R10", "bad calibration aborts", lo_lim_q, 16'hF600);
    put_byte(8'h55); put_byte(glb_cmd(2'b10, 0)); put_byte(8'h03); put_byte(8'h04);
    check(lo_lim_q == 16'hF600, "R10", "bytes without marker ignored", lo_lim_q, 16'hF600);

    // R11 marker restarts partial write and pending reply
    put_sot(); put_byte(8'h55); put_byte(glb_cmd(2'b01, 0)); put_byte(8'h77);
    do_write(glb_cmd(2'b10, 0), 16'h0BCD);
    check(lo_lim_q == 16'h0BCD && cfg_q == 16'hA1B2, "R11", "restart after partial write",
          {lo_lim_q, cfg_q}, 32'h0BCDA1B2);
    put_sot(); put_byte(8'h55); put_byte(glb_cmd(2'b10, 1));
    check(tx_req == 1'b1 && tx_byte == 8'hCD, "R6", "reply low byte", {tx_req, tx_byte}, 9'h1CD);
    put_sot();
    check(tx_req == 1'b0, "R11", "marker withdraws reply", tx_req, 0);
    tick();

    // R8 broadcast strobes
    opcode(8'h8C, 4'b0100, "R8");
    opcode(8'h90, 4'b0010, "R8");
    opcode(8'hA9, 4'b0001, "R8");
    check(cfg_q == 16'hA1B2, "R8", "strobes keep registers", cfg_q, 16'hA1B2);

    // R7 software reset
    opcode(8'hB4, 4'b1001, "R7");
    check(temp_q == 16'h0000 && cfg_q == 16'h0200, "R7", "registers back to reset",
          {temp_q, cfg_q}, 32'h00000200);
    check(lo_lim_q == 16'hF600 && hi_lim_q == 16'h3C00, "R7", "limits back to reset",
          {lo_lim_q, hi_lim_q}, 32'hF6003C00);

    repeat (3) tick();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule